// File: doc/BRIEF.md
# GPIO Pin Interrupt Unit

This block watches a bank of general-purpose input pins and turns selected activity on them into one interrupt request. Software configures it through a small word-addressed register bus. For each pin it chooses edge or level detection, a polarity, and whether an edge trigger fires on both transitions. It can enable or mask the pin on its own. Detected events latch into a status register. Software reads that register and acknowledges events by writing ones to a clear register.

Every pin passes through a two-flop synchronizer before any trigger logic sees it. The same polarity bit serves both families of trigger. In level mode it picks between high and low. In single-edge mode it picks between rising and falling. A level trigger sets its status again on every cycle the level stays active, so an acknowledge only sticks once the pin has gone inactive.

Top module: `pin_event_irq_unit`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 0.
- R2: Writable registers read back the written value in bits below NUM_PINS and 0 above. The offsets are: enable 0x20, mask 0x2C, trigger type 0x34, both-edge 0x38, polarity 0x3C. Raw status reads at 0x24 and masked status at 0x28. The clear register at 0x30 reads 0.
- R3: A pin change that is set up before rising edge k shows in raw status after rising edge k+2, and not earlier.
- R4: With type bit 1 (level), polarity 0 triggers on a high input and polarity 1 triggers on a low input.
- R5: With type bit 0 (edge) and both-edge bit 0, polarity 0 triggers on a rising transition and polarity 1 triggers on a falling transition.
- R6: With type bit 0 and both-edge bit 1, either transition triggers, whatever the polarity. In level mode the both-edge bit has no effect.
- R7: A pin whose enable bit is 0 never sets its raw status bit.
- R8: Writing 1 to a clear bit clears that raw status bit. Writing 0 leaves it unchanged. A trigger in the same cycle wins over the clear, so an active level stays latched.
- R9: Masked status equals raw status AND NOT mask. Mask 0 means the pin is unmasked.
- R10: `irq_out` is 1 exactly when any masked status bit is 1.
- R11: An edge-triggered status bit stays latched after the pin returns to its old value, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume a fixed ordering inside one clock. A status bit rises only after the trigger logic flagged that pin on the cycle before, and it falls only after a clear write naming that bit. Both rules depend on the bus writing and the pins changing only between clock edges. The stimulus changes pins and bus signals on the falling edge only, which keeps that order. Before each pair of pin values is compared, the bench holds the first value long enough to pass the synchronizer and then clears status. Each latched bit therefore comes from one known transition, or from a level that is still active.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    // Register offsets; software depends on these values
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_TYPE   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h3C;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.stable;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] is_level_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] trig_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic lvl_hit, rise, fall, edge_hit;
        // polarity 1 inverts the sense in both families
        assign lvl_hit  = cur_i[p] ^ pol_i[p];
        assign rise     = cur_i[p] & ~prev_i[p];
        assign fall     = ~cur_i[p] & prev_i[p];
        assign edge_hit = both_i[p] ? (rise | fall)
                                    : (pol_i[p] ? fall : rise);
        assign trig_o[p] = is_level_i[p] ? lvl_hit : edge_hit;
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [W-1:0]      trig_i,
    output logic [W-1:0]      is_level_o,
    output logic [W-1:0]      both_o,
    output logic [W-1:0]      pol_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mask;
        logic [W-1:0] is_level;
        logic [W-1:0] both;
        logic [W-1:0] pol;
        logic [W-1:0] raw;
    } regs_t;

    regs_t st_d, st_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] wval;
    logic [W-1:0] masked;

    assign wval    = wdata_i[W-1:0];
    assign clr_vec = (wr_i && addr_i == OFF_CLEAR) ? wval : '0;
    assign masked  = st_q.raw & ~st_q.mask;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                OFF_ENABLE: st_d.en       = wval;
                OFF_MASK:   st_d.mask     = wval;
                OFF_TYPE:   st_d.is_level = wval;
                OFF_BOTH:   st_d.both     = wval;
                OFF_POL:    st_d.pol      = wval;
                default:    ;
            endcase
        end
        // a trigger in the same cycle overrides the acknowledge
        st_d.raw = (st_q.raw & ~clr_vec) | (trig_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            OFF_ENABLE: rdata_o = DATA_W'(st_q.en);
            OFF_RAW:    rdata_o = DATA_W'(st_q.raw);
            OFF_MASKED: rdata_o = DATA_W'(masked);
            OFF_MASK:   rdata_o = DATA_W'(st_q.mask);
            OFF_TYPE:   rdata_o = DATA_W'(st_q.is_level);
            OFF_BOTH:   rdata_o = DATA_W'(st_q.both);
            OFF_POL:    rdata_o = DATA_W'(st_q.pol);
            default:    rdata_o = '0;
        endcase
    end

    assign is_level_o = st_q.is_level;
    assign both_o     = st_q.both;
    assign pol_o      = st_q.pol;
    assign irq_o      = |masked;

    // R7
    disabled_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.raw & ~$past(st_q.raw) & ~$past(st_q.en)) == '0));

    // R3
    set_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.raw & ~$past(st_q.raw) & ~$past(trig_i)) == '0));

    // R8
    trigger_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_i & st_q.en) != '0) |=>
        ((st_q.raw & $past(trig_i & st_q.en)) == $past(trig_i & st_q.en)));

    // R8
    fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.raw) & ~st_q.raw & ~$past(clr_vec)) == '0));

    // R10
    full_mask_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |-> !irq_o);
endmodule

// File: rtl/pin_event_irq_unit.sv
module pin_event_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] cur, prev, trig, is_level, both, pol;

    pin_irq_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cur_o  (cur),
        .prev_o (prev)
    );

    pin_irq_detect #(.W(NUM_PINS)) u_detect (
        .cur_i      (cur),
        .prev_i     (prev),
        .is_level_i (is_level),
        .both_i     (both),
        .pol_i      (pol),
        .trig_o     (trig)
    );

    pin_irq_regs #(.W(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .trig_i     (trig),
        .is_level_o (is_level),
        .both_o     (both),
        .pol_o      (pol),
        .irq_o      (irq_out)
    );
endmodule

// File: tb/pin_event_irq_unit_bench.sv
module pin_event_irq_unit_bench;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pin_event_irq_unit #(.NUM_PINS(NP)) u_pin_event_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0] offs [8];
        offs = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C};

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(offs[i], v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        // R2: readback, upper bits read zero
        wr(8'h2C, 32'hFFFF_FFF9); rd(8'h2C, v); chk("R2 mask", v, 32'h9);
        wr(8'h34, 32'hA5A5_A5A6); rd(8'h34, v); chk("R2 type", v, 32'h6);
        wr(8'h38, 32'h0000_0003); rd(8'h38, v); chk("R2 both", v, 32'h3);
        wr(8'h3C, 32'h1234_567C); rd(8'h3C, v); chk("R2 pol", v, 32'hC);
        wr(8'h20, 32'hFFFF_FFF5); rd(8'h20, v); chk("R2 enable", v, 32'h5);
        rd(8'h30, v); chk("R2 clear reads zero", v, 32'h0);

        // R3: single-edge rising latency on pin 0, all enabled, unmasked
        wr(8'h2C, 0); wr(8'h34, 0); wr(8'h38, 0); wr(8'h3C, 0);
        wr(8'h20, 32'hF); wr(8'h30, 32'hF);
        @(negedge clk);
        reg_addr = 8'h24;
        pin_in = 4'b0001;
        @(negedge clk); #1 chk("R3 after 1 edge", reg_rdata, 32'h0);
        @(negedge clk); #1 chk("R3 after 2 edges", reg_rdata, 32'h0);
        @(negedge clk); #1 chk("R3 after 3 edges", reg_rdata, 32'h1);
        chk("R10 irq raised", {31'b0, irq_out}, 32'h1);

        // R11: edge status stays latched when the pin returns
        pin_in = 4'b0000;
        wait_n(5);
        rd(8'h24, v); chk("R11 latched", v, 32'h1);

        // R8: writing zero to clear has no effect, one clears
        wr(8'h30, 32'h0); rd(8'h24, v); chk("R8 clear zero", v, 32'h1);
        wr(8'h30, 32'h1); rd(8'h24, v); chk("R8 clear one", v, 32'h0);
        chk("R10 irq dropped", {31'b0, irq_out}, 32'h0);

        // R8: an active level survives a clear
        wr(8'h34, 32'hF);
        pin_in = 4'b0100;
        wait_n(5);
        wr(8'h30, 32'hF); rd(8'h24, v); chk("R8 level persists", v, 32'h4);
        pin_in = 4'b0000;
        wait_n(5);
        rd(8'h24, v); chk("R8 still latched after level drop", v, 32'h4);
        wr(8'h30, 32'hF); rd(8'h24, v); chk("R8 cleared once inactive", v, 32'h0);

        // R7: a disabled pin never sets status
        wr(8'h34, 0);
        wr(8'h20, 32'h7);
        pin_in = 4'b1000;
        wait_n(5);
        rd(8'h24, v); chk("R7 disabled pin", v, 32'h0);
        chk("R7 irq", {31'b0, irq_out}, 32'h0);
        pin_in = 4'b0000;
        wait_n(5);
        wr(8'h20, 32'hF);

        // R4 R5 R6 R9 R10: sweep of every mode and every pair of pin values
        for (int m = 0; m < 8; m++) begin
            logic t, b, p;
            t = m[2]; b = m[1]; p = m[0];
            wr(8'h34, {28'b0, {NP{t}}});
            wr(8'h38, {28'b0, {NP{b}}});
            wr(8'h3C, {28'b0, {NP{p}}});
            for (int a = 0; a < 16; a++) begin
                for (int z = 0; z < 16; z++) begin
                    logic [3:0] av, bv, ex, mk, actA, actB;
                    av = 4'(a); bv = 4'(z); mk = 4'(a + 3 * z);
                    wr(8'h2C, {28'b0, mk});
                    pin_in = av;
                    wait_n(4);
                    wr(8'h30, 32'hF);
                    pin_in = bv;
                    wait_n(4);
                    actA = p ? ~av : av;
                    actB = p ? ~bv : bv;
                    if (t)      ex = actA | actB;
                    else if (b) ex = av ^ bv;
                    else if (p) ex = av & ~bv;
                    else        ex = ~av & bv;
                    rd(8'h24, v);
                    if (t) chk("R4 R6 level raw", v, {28'b0, ex});
                    else if (b) chk("R6 both-edge raw", v, {28'b0, ex});
                    else chk("R5 single-edge raw", v, {28'b0, ex});
                    rd(8'h28, v); chk("R9 masked", v, {28'b0, ex & ~mk});
                    chk("R10 irq", {31'b0, irq_out}, {31'b0, |(ex & ~mk)});
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule